// File: doc/BRIEF.md
# Power Supply Sequencer

This block turns a set of power-supply enable outputs on and off in a fixed order of time slots. When the qualified enable (comparator level AND software bit) comes up, it walks slots 0 to 6. Each output switches on in the slot assigned to it, and after the last slot the block settles in a monitoring state. When the enable goes away, it walks the same slots downward and switches each output off in its slot, until nothing is left on.

The wait spent in each slot is set by an 8-bit code split into a 4-bit exponent and a 4-bit mantissa. It is counted in pulses of an external 5 µs tick. A fault reported by an external voltage monitor during power-up or monitoring drops every output at once and parks the block in a fault state. The block leaves that state either as soon as the fault clears, or, in latch mode, only once the enable has also been withdrawn. A sticky flag records shutdowns caused by a falling enable while monitoring, and software clears it.

Top module: `pwr_sequencer`

## Requirements
- R1: After reset `stateCode` is 0, all `chEn` bits are 0 and `enRstFlag` is 0. `stateCode` is `slot` (0 to 6) while sequencing, 7 in the monitoring state and 8 in the fault state; idle also reads 0, and codes 9 to 15 never occur.
- R2: Power-up starts only while both `enCmp` and `swEn` are 1. It visits slots 0 to 6 in rising order and then enters the monitoring state. Channel i, whose slot number sits in `slotMap[3i+2:3i]`, turns on at the edge that enters its slot and stays on.
- R3: Slot k waits for (16 + b) × 2^a tick pulses, where a = `delayCodes[8k+7:8k+4]` and b = `delayCodes[8k+3:8k]`. A pulse in the cycle of slot entry is not counted. Slot 6 uses code 6 to reach the monitoring state.
- R4: When the enable drops while monitoring, the block enters slot 6 going downward and turns off the slot-6 channels on that edge. From downward slot k (k > 0) it waits for the time given by code k-1, then enters slot k-1 and turns off that slot's channels.
- R5: If the enable returns during power-down, the block still reaches slot 0 with all outputs off. On the next edge it enters power-up slot 0.
- R6: `faultIn` high during power-up or monitoring moves the block to code 8 with all outputs off at the next edge.
- R7: With `latchMode` = 0 the block leaves the fault state for idle on the first edge at which `faultIn` is 0. It restarts power-up on the following edge if enabled.
- R8: With `latchMode` = 1 the block stays in the fault state while the enable is high. It goes to idle only at an edge where `faultIn` is 0 and the enable is low.
- R9: `enRstFlag` becomes 1 only at an edge where the block is monitoring and `enCmp` or `swEn` has just fallen. A falling enable in any other state leaves the flag unchanged.
- R10: A one-cycle pulse on `flagClr` clears `enRstFlag` at the next edge. A new set in the same cycle takes priority.
- R11: If the enable drops during power-up at slot k, the block goes downward from slot k. It turns off the slot-k channels at once and then continues as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 5 µs time base pulse |
| enCmp | input | 1 | Debounced enable comparator level |
| swEn | input | 1 | Software enable bit |
| faultIn | input | 1 | Fault from the external voltage monitor |
| latchMode | input | 1 | 1 = latch in fault until the enable is withdrawn |
| flagClr | input | 1 | Clear pulse for the sticky flag |
| slotMap | input | 18 | 3-bit slot number per channel, channel i at [3i+2:3i] |
| delayCodes | input | 56 | 8-bit delay code per slot, slot k at [8k+7:8k] |
| chEn | output | 6 | Channel enable outputs |
| stateCode | output | 4 | Current sequencer state code |
| enRstFlag | output | 1 | Sticky enable-driven shutdown flag |

## Verification
Enables, faults and clears are driven just after a falling clock edge. The state code, channel enables and flag all move at the next rising edge, so every such check reads them at the following falling edge. A slot change is due at the edge that samples the (16 + b) × 2^a-th tick after entry. The bench counts the ticks present at each rising edge from one state-code change to the next and compares that count with the code. For power-up slot 0, which shares code 0 with idle, the count restarts at the edge that enters it.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int SLOT_W = 3;
  localparam int STATE_W = 4;

  localparam logic [STATE_W-1:0] CODE_IDLE  = 4'd0;
  localparam logic [STATE_W-1:0] CODE_ON    = 4'd7;
  localparam logic [STATE_W-1:0] CODE_FAULT = 4'd8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_UP,
    PH_ON,
    PH_DOWN,
    PH_FAULT
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              loadDly;
    logic [SLOT_W-1:0] dlyIdx;
    logic              setSlot;
    logic              clrSlot;
    logic [SLOT_W-1:0] slotIdx;
    logic              clrAll;
  } strobe_t;
endpackage

// File: rtl/seq_dpath.sv
module seq_dpath
  import seq_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int NUM_SLOTS = 7,
  parameter int EXP_W     = 4,
  parameter int MANT_W    = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              tick,
  input  strobe_t                           stb,
  input  logic [NUM_CH*SLOT_W-1:0]          slotMap,
  input  logic [NUM_SLOTS*(EXP_W+MANT_W)-1:0] delayCodes,
  output logic                              dlyDone,
  output logic [NUM_CH-1:0]                 chEn
);
  localparam int CODE_W = EXP_W + MANT_W;
  localparam int TERM_W = MANT_W + 1 + (2 ** EXP_W) - 1;

  // ---------------- delay timer ----------------
  logic [CODE_W-1:0] codeArr [NUM_SLOTS];
  logic [CODE_W-1:0] selCode;
  logic [TERM_W-1:0] termNext;
  logic [TERM_W-1:0] termReg;
  logic [TERM_W-1:0] cnt;
  logic              armed;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_code
    assign codeArr[k] = delayCodes[k*CODE_W +: CODE_W];
  end

  always_comb begin
    selCode = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (stb.dlyIdx == SLOT_W'(k)) selCode = codeArr[k];
    end
    // (16 + mantissa) shifted left by the exponent
    termNext = {{(TERM_W-MANT_W-1){1'b0}}, 1'b1, selCode[MANT_W-1:0]}
               << selCode[CODE_W-1 -: EXP_W];
  end

  assign dlyDone = armed && tick && (cnt == termReg - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      termReg <= '0;
      cnt     <= '0;
      armed   <= 1'b0;
    end else if (stb.loadDly) begin
      termReg <= termNext;
      cnt     <= '0;
      armed   <= 1'b1;
    end else if (stb.clrAll || dlyDone) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (armed && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // counter never reaches the terminal count while armed (R3)
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (cnt < termReg));

  // a fresh load always starts the count from zero (R3)
  p_load_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadDly |=> (cnt == '0) && armed);

  // ---------------- channel enable bank ----------------
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [SLOT_W-1:0] mySlot;
    logic              onReg;
    assign mySlot = slotMap[i*SLOT_W +: SLOT_W];

    always_ff @(posedge clk) begin
      if (!rstN)                                       onReg <= 1'b0;
      else if (stb.clrAll)                             onReg <= 1'b0;
      else if (stb.setSlot && mySlot == stb.slotIdx)   onReg <= 1'b1;
      else if (stb.clrSlot && mySlot == stb.slotIdx)   onReg <= 1'b0;
    end

    assign chEn[i] = onReg;
  end

  // a shutdown strobe leaves nothing on (R6)
  p_all_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrAll |=> (chEn == '0));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int NUM_SLOTS = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enCmp,
  input  logic               swEn,
  input  logic               faultIn,
  input  logic               latchMode,
  input  logic               flagClr,
  input  logic               dlyDone,
  output strobe_t            stb,
  output logic [STATE_W-1:0] stateCode,
  output logic               enRstFlag
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  phase_e            phase, nPhase;
  logic [SLOT_W-1:0] slot, nSlot;
  logic              enable;
  logic              prevCmp, prevSw;
  logic              fallEdge, flagSet;

  assign enable   = enCmp && swEn;
  assign fallEdge = (prevCmp && !enCmp) || (prevSw && !swEn);
  assign flagSet  = (phase == PH_ON) && fallEdge;

  always_comb begin
    nPhase = phase;
    nSlot  = slot;
    stb    = '0;
    unique case (phase)
      PH_IDLE: begin
        if (enable) begin
          nPhase      = PH_UP;
          nSlot       = '0;
          stb.setSlot = 1'b1;
          stb.slotIdx = '0;
          stb.loadDly = 1'b1;
          stb.dlyIdx  = '0;
        end
      end
      PH_UP: begin
        if (faultIn) begin
          nPhase     = PH_FAULT;
          stb.clrAll = 1'b1;
        end else if (!enable) begin
          nPhase      = PH_DOWN;
          stb.clrSlot = 1'b1;
          stb.slotIdx = slot;
          stb.loadDly = (slot != '0);
          stb.dlyIdx  = slot - 1'b1;
        end else if (dlyDone) begin
          if (slot == LAST_SLOT) begin
            nPhase = PH_ON;
          end else begin
            nSlot       = slot + 1'b1;
            stb.setSlot = 1'b1;
            stb.slotIdx = slot + 1'b1;
            stb.loadDly = 1'b1;
            stb.dlyIdx  = slot + 1'b1;
          end
        end
      end
      PH_ON: begin
        if (faultIn) begin
          nPhase     = PH_FAULT;
          stb.clrAll = 1'b1;
        end else if (!enable) begin
          nPhase      = PH_DOWN;
          nSlot       = LAST_SLOT;
          stb.clrSlot = 1'b1;
          stb.slotIdx = LAST_SLOT;
          stb.loadDly = (LAST_SLOT != '0);
          stb.dlyIdx  = LAST_SLOT - 1'b1;
        end
      end
      PH_DOWN: begin
        if (slot == '0) begin
          if (enable) begin
            nPhase      = PH_UP;
            stb.setSlot = 1'b1;
            stb.slotIdx = '0;
            stb.loadDly = 1'b1;
            stb.dlyIdx  = '0;
          end else begin
            nPhase = PH_IDLE;
          end
        end else if (dlyDone) begin
          nSlot       = slot - 1'b1;
          stb.clrSlot = 1'b1;
          stb.slotIdx = slot - 1'b1;
          stb.loadDly = (slot != SLOT_W'(1));
          stb.dlyIdx  = slot - SLOT_W'(2);
        end
      end
      PH_FAULT: begin
        if (!faultIn && (!latchMode || !enable)) nPhase = PH_IDLE;
      end
      default: nPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      slot      <= '0;
      prevCmp   <= 1'b0;
      prevSw    <= 1'b0;
      enRstFlag <= 1'b0;
    end else begin
      phase   <= nPhase;
      slot    <= nSlot;
      prevCmp <= enCmp;
      prevSw  <= swEn;
      if (flagSet)      enRstFlag <= 1'b1;
      else if (flagClr) enRstFlag <= 1'b0;
    end
  end

  always_comb begin
    unique case (phase)
      PH_UP, PH_DOWN: stateCode = {1'b0, slot};
      PH_ON:          stateCode = CODE_ON;
      PH_FAULT:       stateCode = CODE_FAULT;
      default:        stateCode = CODE_IDLE;
    endcase
  end

  // only the defined codes appear (R1)
  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    stateCode <= CODE_FAULT);

  // fault while powering up or running reaches the fault state (R6)
  p_fault_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (faultIn && (phase == PH_UP || phase == PH_ON)) |=> (stateCode == CODE_FAULT));

  // finished power-down with enable back restarts at slot 0 (R5)
  p_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DOWN && slot == '0 && enable) |=> (phase == PH_UP && slot == '0));

  // latch mode holds the fault state while still enabled (R8)
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FAULT && latchMode && enable) |=> (phase == PH_FAULT));

  // sticky flag only rises out of the monitoring state (R9)
  p_flag_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enRstFlag) |-> $past(phase == PH_ON));

  // clear outside monitoring always takes effect (R10)
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && phase != PH_ON) |=> !enRstFlag);

endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int NUM_SLOTS = 7,
  parameter int EXP_W     = 4,
  parameter int MANT_W    = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                tick,
  input  logic                                enCmp,
  input  logic                                swEn,
  input  logic                                faultIn,
  input  logic                                latchMode,
  input  logic                                flagClr,
  input  logic [NUM_CH*SLOT_W-1:0]            slotMap,
  input  logic [NUM_SLOTS*(EXP_W+MANT_W)-1:0] delayCodes,
  output logic [NUM_CH-1:0]                   chEn,
  output logic [STATE_W-1:0]                  stateCode,
  output logic                                enRstFlag
);
  strobe_t stb;
  logic    dlyDone;

  seq_ctrl #(
    .NUM_SLOTS (NUM_SLOTS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enCmp     (enCmp),
    .swEn      (swEn),
    .faultIn   (faultIn),
    .latchMode (latchMode),
    .flagClr   (flagClr),
    .dlyDone   (dlyDone),
    .stb       (stb),
    .stateCode (stateCode),
    .enRstFlag (enRstFlag)
  );

  seq_dpath #(
    .NUM_CH    (NUM_CH),
    .NUM_SLOTS (NUM_SLOTS),
    .EXP_W     (EXP_W),
    .MANT_W    (MANT_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .stb        (stb),
    .slotMap    (slotMap),
    .delayCodes (delayCodes),
    .dlyDone    (dlyDone),
    .chEn       (chEn)
  );
endmodule

// File: tb/tb_pwr_sequencer.sv
`timescale 1ns/1ps
module tb_pwr_sequencer;
  localparam int NUM_CH    = 6;
  localparam int NUM_SLOTS = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                  rstN = 1'b0;
  logic                  tick = 1'b0;
  logic                  enCmp = 1'b0, swEn = 1'b0, faultIn = 1'b0;
  logic                  latchMode = 1'b0, flagClr = 1'b0;
  logic [NUM_CH*3-1:0]   slotMap;
  logic [NUM_SLOTS*8-1:0] delayCodes;
  logic [NUM_CH-1:0]     chEn;
  logic [3:0]            stateCode;
  logic                  enRstFlag;

  pwr_sequencer dut (
    .clk(clk), .rstN(rstN), .tick(tick), .enCmp(enCmp), .swEn(swEn),
    .faultIn(faultIn), .latchMode(latchMode), .flagClr(flagClr),
    .slotMap(slotMap), .delayCodes(delayCodes),
    .chEn(chEn), .stateCode(stateCode), .enRstFlag(enRstFlag)
  );

  int checks = 0, failures = 0;
  logic [7:0] dly [NUM_SLOTS] = '{8'h00, 8'h01, 8'h10, 8'h03, 8'h12, 8'h00, 8'h02};
  int chSlot [NUM_CH] = '{2, 0, 5, 2, 6, 3};

  initial begin
    for (int k = 0; k < NUM_SLOTS; k++) delayCodes[k*8 +: 8] = dly[k];
    for (int i = 0; i < NUM_CH; i++) slotMap[i*3 +: 3] = 3'(chSlot[i]);
  end

  function automatic int expTicks(logic [7:0] c);
    return (16 + int'(c[3:0])) << c[7:4];
  endfunction

  function automatic logic [NUM_CH-1:0] maskUpTo(int s);
    logic [NUM_CH-1:0] m = '0;
    for (int i = 0; i < NUM_CH; i++) if (chSlot[i] <= s) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [NUM_CH-1:0] maskBelow(int s);
    logic [NUM_CH-1:0] m = '0;
    for (int i = 0; i < NUM_CH; i++) if (chSlot[i] < s) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tick generator and per-state tick/snapshot monitor
  int         tickCnt = 0;
  int         divCnt = 0;
  int         dur [16];
  logic [5:0] snap [16];
  logic [3:0] lastCode = 4'd0;
  bit         zeroReq = 1'b0;

  always @(negedge clk) begin
    if (tick) tickCnt++;
    if (zeroReq) begin
      tickCnt = 0;
      zeroReq = 1'b0;
    end else if (stateCode != lastCode) begin
      dur[lastCode]   = tickCnt;
      snap[stateCode] = chEn;
      tickCnt         = 0;
    end
    lastCode = stateCode;
    if (!rstN) begin
      tick   = 1'b0;
      divCnt = 0;
    end else begin
      tick   = (divCnt == 2);
      divCnt = (divCnt + 1) % 3;
    end
  end

  task automatic waitCode(logic [3:0] c);
    @(negedge clk);
    while (stateCode !== c) @(negedge clk);
    #1;
  endtask

  task automatic nextSample();
    @(negedge clk);
    #1;
  endtask

  task automatic pulseClear();
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    #1;
  endtask

  task automatic goIdle();
    @(negedge clk);
    swEn = 1'b0;
    waitCode(4'd0);
    repeat (3) nextSample();
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    nextSample();
    check(stateCode == 4'd0, "R1 reset code", stateCode, 0);
    check(chEn == '0, "R1 reset enables", chEn, 0);
    check(enRstFlag == 1'b0, "R1 reset flag", enRstFlag, 0);
  endtask

  task automatic testPowerUp();
    enCmp = 1'b1;
    repeat (6) nextSample();
    check(stateCode == 4'd0 && chEn == '0, "R2 needs both enables", chEn, 0);
    @(negedge clk);
    swEn = 1'b1;
    @(posedge clk);
    #1 zeroReq = 1'b1;
    nextSample();
    check(chEn == maskUpTo(0), "R2 slot0 enables", chEn, maskUpTo(0));
    waitCode(4'd7);
    for (int k = 1; k < NUM_SLOTS; k++)
      check(snap[k] == maskUpTo(k), $sformatf("R2 enables at slot %0d", k), snap[k], maskUpTo(k));
    check(snap[7] == '1, "R2 all on in monitoring", snap[7], 63);
    for (int k = 0; k < NUM_SLOTS; k++)
      check(dur[k] == expTicks(dly[k]), $sformatf("R3 up delay slot %0d", k), dur[k], expTicks(dly[k]));
  endtask

  task automatic testPowerDown();
    @(negedge clk);
    enCmp = 1'b0;
    nextSample();
    check(stateCode == 4'd6, "R4 enters slot 6", stateCode, 6);
    check(chEn == maskBelow(6), "R4 slot6 off", chEn, maskBelow(6));
    check(enRstFlag == 1'b1, "R9 flag set on drop", enRstFlag, 1);
    waitCode(4'd1);
    waitCode(4'd0);
    for (int k = 1; k < NUM_SLOTS; k++)
      check(dur[k] == expTicks(dly[k-1]), $sformatf("R4 down delay slot %0d", k), dur[k], expTicks(dly[k-1]));
    for (int k = 0; k < NUM_SLOTS - 1; k++)
      check(snap[k] == maskBelow(k), $sformatf("R4 enables at down slot %0d", k), snap[k], maskBelow(k));
    repeat (3) nextSample();
    check(enRstFlag == 1'b1, "R9 flag sticky", enRstFlag, 1);
    pulseClear();
    check(enRstFlag == 1'b0, "R10 flag cleared", enRstFlag, 0);
  endtask

  task automatic testRestart();
    @(negedge clk);
    enCmp = 1'b1;
    waitCode(4'd7);
    @(negedge clk);
    enCmp = 1'b0;
    waitCode(4'd3);
    enCmp = 1'b1;
    waitCode(4'd0);
    check(chEn == '0, "R5 all off before restart", chEn, 0);
    nextSample();
    check(stateCode == 4'd0 && chEn == maskUpTo(0), "R5 restart at slot0", chEn, maskUpTo(0));
    waitCode(4'd7);
    check(chEn == '1, "R5 back to all on", chEn, 63);
    pulseClear();
  endtask

  task automatic testDropDuringUp();
    goIdle();
    pulseClear();
    swEn = 1'b1;
    waitCode(4'd2);
    swEn = 1'b0;
    nextSample();
    check(stateCode == 4'd2 && chEn == maskBelow(2), "R11 down from slot2", chEn, maskBelow(2));
    check(enRstFlag == 1'b0, "R9 no flag outside monitoring", enRstFlag, 0);
    waitCode(4'd1);
    waitCode(4'd0);
    check(dur[1] == expTicks(dly[0]), "R11 down slot1 delay", dur[1], expTicks(dly[0]));
    check(chEn == '0, "R11 all off", chEn, 0);
    repeat (3) nextSample();
  endtask

  task automatic testFaultNoLatch();
    latchMode = 1'b0;
    swEn = 1'b1;
    waitCode(4'd3);
    faultIn = 1'b1;
    nextSample();
    check(stateCode == 4'd8, "R6 fault code in power-up", stateCode, 8);
    check(chEn == '0, "R6 outputs dropped", chEn, 0);
    repeat (3) nextSample();
    faultIn = 1'b0;
    nextSample();
    check(stateCode == 4'd0 && chEn == '0, "R7 idle after fault clears", stateCode, 0);
    nextSample();
    check(chEn == maskUpTo(0), "R7 restart slot0", chEn, maskUpTo(0));
    waitCode(4'd7);
    faultIn = 1'b1;
    nextSample();
    check(stateCode == 4'd8 && chEn == '0, "R6 fault in monitoring", chEn, 0);
    faultIn = 1'b0;
    waitCode(4'd7);
  endtask

  task automatic testFaultLatch();
    latchMode = 1'b1;
    faultIn = 1'b1;
    nextSample();
    check(stateCode == 4'd8, "R8 fault entered", stateCode, 8);
    swEn = 1'b0;
    repeat (3) nextSample();
    check(stateCode == 4'd8, "R8 held while fault present", stateCode, 8);
    swEn = 1'b1;
    nextSample();
    faultIn = 1'b0;
    repeat (5) nextSample();
    check(stateCode == 4'd8, "R8 held while enabled", stateCode, 8);
    swEn = 1'b0;
    nextSample();
    check(stateCode == 4'd0 && chEn == '0, "R8 idle after toggle off", stateCode, 0);
    check(enRstFlag == 1'b0, "R9 no flag from fault state", enRstFlag, 0);
    swEn = 1'b1;
    nextSample();
    check(chEn == maskUpTo(0), "R8 restart after toggle on", chEn, maskUpTo(0));
    latchMode = 1'b0;
  endtask

  initial begin
    testReset();
    testPowerUp();
    testPowerDown();
    testRestart();
    testDropDuringUp();
    testFaultNoLatch();
    testFaultLatch();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule